// File: doc/BRIEF.md
# Transfer Descriptor Splitter

This block takes one buffer request and turns it into a run of 128-bit transfer descriptors. A request is a 64-bit start address plus a byte count. Every descriptor covers a piece of the buffer that stays inside one 64 KB-aligned address window. Each descriptor carries:

- the piece's pointer and length;
- a coarse 5-bit estimate of the bytes still to go;
- a chain flag that links it to the next descriptor;
- a completion flag on the final piece;
- the producer cycle state that was present when the request was taken.

Requests longer than the 64 MB per-transfer limit are refused with a one-cycle error pulse. A refused request produces no descriptor.

Both the request side and the descriptor side are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a transfer is being split, so only one request is in flight. A descriptor is taken on an edge where `trb_valid` and `trb_ready` are both high. While `trb_valid` is high and `trb_ready` is low, the descriptor is held unchanged. `cycle_in`, `done` and `err` are plain pins.

Top module: `trbs_splitter`

## Requirements
- R1: After reset, `req_ready` is 1 and `trb_valid`, `done` and `err` are 0.
- R2: A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The first descriptor is valid in the next cycle, and `req_ready` stays low until the final descriptor has been taken.
- R3: Descriptor layout, with every other bit 0:
  - bits [63:0]: buffer pointer;
  - bits [80:64]: segment length in bytes;
  - bits [85:81]: remaining-size code;
  - bit 96: cycle;
  - bit 97: chain;
  - bit 98: interrupt on completion.
- R4: Each descriptor's length is the smaller of two values: the bytes still to be described, and the bytes up to the next 64 KB address boundary. The next pointer is the current pointer plus that length, so no descriptor crosses a boundary.
- R5: The remaining-size code is the bytes still to be described, counting this descriptor, shifted right by 10. The code is 0 below 1024 bytes and saturates at 31 above 32767 bytes.
- R6: The chain bit is 1 on every descriptor except the last. The completion bit is 1 only on the last.
- R7: The cycle bit of every descriptor equals `cycle_in` as sampled when the request was taken. Later changes of `cycle_in` have no effect on that transfer.
- R8: A zero-length request produces exactly one descriptor, with length 0, size code 0, chain 0 and completion 1.
- R9: While `trb_valid` is high and `trb_ready` is low, `trb_valid` stays high and `trb_data` stays unchanged in the next cycle.
- R10: A request longer than 2^26 bytes is taken and pulses `err` for one cycle in the next cycle. It produces no descriptor and no `done`. A request of exactly 2^26 bytes is split normally.
- R11: `done` pulses for one cycle in the cycle after the final descriptor's handshake, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_in | input | 1 | Producer cycle state, sampled when a request is taken |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_addr | input | 64 | Buffer start address |
| req_len | input | 27 | Buffer length in bytes |
| trb_valid | output | 1 | Descriptor valid |
| trb_ready | input | 1 | Descriptor ready |
| trb_data | output | 128 | Descriptor word |
| done | output | 1 | Transfer finished pulse |
| err | output | 1 | Over-long request pulse |

## Verification
The bench builds the block with its defaults:

- a 64-bit address;
- a 27-bit length;
- a 64 KB boundary;
- a shift of 10 with a 5-bit size code.

The 27-bit length makes both sides of the 64 MB limit reachable: 2^26 bytes splits into 1024 descriptors, and one byte more is refused. Addresses just below a boundary force short first pieces, and lengths of 1024, 32767 and 32768 bytes hit the edges of the size code. The descriptor port is also driven with a stalling ready pattern to exercise holding under back-pressure.

// File: rtl/trbs_pkg.sv
package trbs_pkg;
  localparam int TRB_W     = 128;
  localparam int PTR_LSB   = 0;
  localparam int SEGL_LSB  = 64;
  localparam int SEGL_BITS = 17;
  localparam int CODE_LSB  = 81;
  localparam int CODE_BITS = 5;
  localparam int CYC_BIT   = 96;
  localparam int CHAIN_BIT = 97;
  localparam int IOC_BIT   = 98;

  typedef enum logic {ST_IDLE, ST_EMIT} split_state_e;

  function automatic logic [TRB_W-1:0] pack_trb(
    input logic [63:0]          ptr,
    input logic [SEGL_BITS-1:0] seg_len,
    input logic [CODE_BITS-1:0] code,
    input logic                 cyc,
    input logic                 chain,
    input logic                 ioc
  );
    logic [TRB_W-1:0] w;
    w = '0;
    w[PTR_LSB +: 64]          = ptr;
    w[SEGL_LSB +: SEGL_BITS]  = seg_len;
    w[CODE_LSB +: CODE_BITS]  = code;
    w[CYC_BIT]                = cyc;
    w[CHAIN_BIT]              = chain;
    w[IOC_BIT]                = ioc;
    return w;
  endfunction
endpackage

// File: rtl/trbs_len_check.sv
module trbs_len_check #(
  parameter int LEN_W = 27
) (
  input  logic [LEN_W-1:0] len,
  output logic             too_long
);
  localparam logic [LEN_W-1:0] LIMIT = {1'b1, {(LEN_W-1){1'b0}}};
  assign too_long = len > LIMIT;
endmodule

// File: rtl/trbs_seg_calc.sv
module trbs_seg_calc #(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 27,
  parameter int BOUND_LOG2 = 16
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LEN_W-1:0]    rem,
  output logic [BOUND_LOG2:0] seg,
  output logic                last
);
  localparam int SEG_W = BOUND_LOG2 + 1;
  localparam int CMP_W = (LEN_W > SEG_W) ? LEN_W : SEG_W;

  logic [SEG_W-1:0] to_bound;
  logic [CMP_W-1:0] rem_x;
  logic [CMP_W-1:0] bnd_x;

  // bytes from addr up to (and excluding) the next aligned boundary
  assign to_bound = {1'b1, {BOUND_LOG2{1'b0}}} - {1'b0, addr[BOUND_LOG2-1:0]};
  assign rem_x    = CMP_W'(rem);
  assign bnd_x    = CMP_W'(to_bound);
  assign last     = rem_x <= bnd_x;
  assign seg      = last ? SEG_W'(rem_x) : to_bound;
endmodule

// File: rtl/trbs_size_enc.sv
module trbs_size_enc #(
  parameter int LEN_W      = 27,
  parameter int SIZE_SHIFT = 10,
  parameter int SIZE_W     = 5
) (
  input  logic [LEN_W-1:0]  rem,
  output logic [SIZE_W-1:0] code
);
  localparam int CAP_LOG2 = SIZE_SHIFT + SIZE_W;

  generate
    if (LEN_W > CAP_LOG2) begin : g_sat
      logic over;
      assign over = |rem[LEN_W-1:CAP_LOG2];
      assign code = over ? {SIZE_W{1'b1}} : rem[CAP_LOG2-1:SIZE_SHIFT];
    end else begin : g_nosat
      assign code = SIZE_W'(rem >> SIZE_SHIFT);
    end
  endgenerate
endmodule

// File: rtl/trbs_splitter.sv
module trbs_splitter
  import trbs_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int LEN_W      = 27,
  parameter int BOUND_LOG2 = 16,
  parameter int SIZE_SHIFT = 10,
  parameter int SIZE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycle_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              trb_valid,
  input  logic              trb_ready,
  output logic [TRB_W-1:0]  trb_data,
  output logic              done,
  output logic              err
);
  localparam int SEG_W = BOUND_LOG2 + 1;

  split_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic              cyc_q;
  logic              done_q;
  logic              err_q;

  logic              too_long;
  logic [SEG_W-1:0]  seg;
  logic              last;
  logic [SIZE_W-1:0] code;
  logic              take_req;
  logic              take_trb;

  trbs_len_check #(.LEN_W(LEN_W)) u_len_check (
    .len      (req_len),
    .too_long (too_long)
  );

  trbs_seg_calc #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BOUND_LOG2 (BOUND_LOG2)
  ) u_seg_calc (
    .addr (addr_q),
    .rem  (rem_q),
    .seg  (seg),
    .last (last)
  );

  trbs_size_enc #(
    .LEN_W      (LEN_W),
    .SIZE_SHIFT (SIZE_SHIFT),
    .SIZE_W     (SIZE_W)
  ) u_size_enc (
    .rem  (rem_q),
    .code (code)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign trb_valid = (state_q == ST_EMIT);
  assign take_req  = req_valid && req_ready;
  assign take_trb  = trb_valid && trb_ready;
  assign done      = done_q;
  assign err       = err_q;

  assign trb_data = pack_trb(64'(addr_q), SEGL_BITS'(seg), CODE_BITS'(code),
                             cyc_q, !last, last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      cyc_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take_req) begin
            if (too_long) begin
              err_q <= 1'b1;
            end else begin
              addr_q  <= req_addr;
              rem_q   <= req_len;
              cyc_q   <= cycle_in;
              state_q <= ST_EMIT;
            end
          end
        end
        ST_EMIT: begin
          if (take_trb) begin
            if (last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              addr_q <= addr_q + ADDR_W'(seg);
              rem_q  <= rem_q - LEN_W'(seg);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trbs_splitter_chk.sv
module trbs_splitter_chk
  import trbs_pkg::*;
#(
  parameter int BOUND_LOG2 = 16,
  parameter int SIZE_SHIFT = 10,
  parameter int SIZE_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             trb_valid,
  input logic             trb_ready,
  input logic [TRB_W-1:0] trb_data,
  input logic             done,
  input logic             err
);
  localparam int CAP_LOG2 = SIZE_SHIFT + SIZE_W;

  logic [BOUND_LOG2:0]    span;
  logic [SEGL_BITS-1:0]   seg_len;
  logic [CODE_BITS-1:0]   code;
  logic [CODE_BITS-1:0]   min_code;
  logic                   chain;
  logic                   ioc;
  logic                   rsvd_zero;

  assign seg_len   = trb_data[SEGL_LSB +: SEGL_BITS];
  assign code      = trb_data[CODE_LSB +: CODE_BITS];
  assign chain     = trb_data[CHAIN_BIT];
  assign ioc       = trb_data[IOC_BIT];
  assign span      = {1'b0, trb_data[BOUND_LOG2-1:0]} + (BOUND_LOG2+1)'(seg_len);
  assign min_code  = (seg_len >= SEGL_BITS'(1 << CAP_LOG2)) ? '1 :
                     CODE_BITS'(seg_len >> SIZE_SHIFT);
  assign rsvd_zero = (trb_data[95:86] == '0) && (trb_data[127:99] == '0);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    trb_valid |-> !req_ready); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trb_valid |-> rsvd_zero); // R3

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    trb_valid |-> span <= {1'b1, {BOUND_LOG2{1'b0}}}); // R4

  AST_CODE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    trb_valid |-> code >= min_code); // R5

  AST_LAST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (trb_valid && ioc) |-> code == min_code); // R5

  AST_CHAIN_IOC: assert property (@(posedge clk) disable iff (!rst_n)
    trb_valid |-> chain != ioc); // R6

  AST_ZERO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (trb_valid && seg_len == '0) |-> ioc); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trb_valid && !trb_ready) |=> (trb_valid && $stable(trb_data))); // R9

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!trb_valid && !done)); // R10

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(trb_valid && trb_ready && ioc)); // R11
endmodule

bind trbs_splitter trbs_splitter_chk #(
  .BOUND_LOG2 (BOUND_LOG2),
  .SIZE_SHIFT (SIZE_SHIFT),
  .SIZE_W     (SIZE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .trb_valid (trb_valid),
  .trb_ready (trb_ready),
  .trb_data  (trb_data),
  .done      (done),
  .err       (err)
);

// File: tb/trbs_splitter_bench.sv
module trbs_splitter_bench;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cycle_in = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [63:0]   req_addr = '0;
  logic [26:0]   req_len = '0;
  logic          trb_valid;
  logic          trb_ready = 1'b0;
  logic [127:0]  trb_data;
  logic          done;
  logic          err;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int good_reqs = 0;
  int rdy_cnt = 0;
  bit bp_mode = 1'b0;
  bit last_pending = 1'b0;
  bit held = 1'b0;
  logic [127:0] held_data = '0;
  logic [127:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trbs_splitter u_trbs_splitter (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_in  (cycle_in),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .trb_valid (trb_valid),
    .trb_ready (trb_ready),
    .trb_data  (trb_data),
    .done      (done),
    .err       (err)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference split built from the requirements
  task automatic build(input logic [63:0] addr, input logic [26:0] len, input bit cyc);
    logic [63:0] a = addr;
    logic [26:0] rem = len;
    bit last = 1'b0;
    while (!last) begin
      logic [16:0] to_b;
      logic [16:0] seg;
      logic [4:0]  code;
      logic [127:0] d;
      to_b = 17'h10000 - {1'b0, a[15:0]};
      last = ({10'b0, to_b} >= rem);
      seg  = last ? rem[16:0] : to_b;
      code = (rem > 27'd32767) ? 5'd31 : rem[14:10];
      d = '0;
      d[63:0] = a; d[80:64] = seg; d[85:81] = code;
      d[96] = cyc; d[97] = !last; d[98] = last;
      exp_q.push_back(d);
      a = a + {47'b0, seg};
      rem = rem - {10'b0, seg};
    end
  endtask

  // monitor: drives ready, pops and compares descriptors
  always @(negedge clk) begin
    if (rst_n) begin
      if (last_pending) chk(done === 1'b1, "R11 done after last", {127'b0, done}, 128'd1);
      else if (done) chk(1'b0, "R11 spurious done", {127'b0, done}, 128'd0);
      if (done) done_cnt++;
      last_pending = 1'b0;
      if (held) chk(trb_valid && trb_data == held_data, "R9 hold", trb_data, held_data);
      rdy_cnt++;
      trb_ready = bp_mode ? (rdy_cnt % 3 == 0) : 1'b1;
      if (trb_valid && trb_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected descriptor", trb_data, '0);
        end else begin
          logic [127:0] e;
          e = exp_q.pop_front();
          chk(trb_data == e, "R3 R4 R5 R6 R7 descriptor", trb_data, e);
          if (trb_data[98]) last_pending = 1'b1;
        end
      end
      held = trb_valid && !trb_ready;
      held_data = trb_data;
    end
  end

  task automatic run_req(input logic [63:0] addr, input logic [26:0] len, input bit cyc,
                         input bit bad);
    @(negedge clk);
    cycle_in = cyc; req_addr = addr; req_len = len; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (!bad) begin
      build(addr, len, cyc);
      good_reqs++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    cycle_in = ~cyc;  // R7: later changes must not matter
    if (bad) begin
      chk(err && !trb_valid, "R10 err pulse", {126'b0, err, trb_valid}, 128'b10);
      @(negedge clk);
      chk(!err && !trb_valid && req_ready, "R10 single pulse, no descriptor",
          {125'b0, err, trb_valid, req_ready}, 128'b001);
    end else begin
      chk(trb_valid && !err && !req_ready, "R2 first descriptor next cycle",
          {125'b0, trb_valid, err, req_ready}, 128'b100);
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(req_ready && !trb_valid, "R2 idle after transfer",
          {126'b0, req_ready, trb_valid}, 128'b10);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !trb_valid && !done && !err, "R1 reset state",
        {124'b0, req_ready, trb_valid, done, err}, 128'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !trb_valid && !done && !err, "R1 after reset release",
        {124'b0, req_ready, trb_valid, done, err}, 128'b1000);

    run_req(64'h0000_0000_0000_1000, 27'd100, 1'b1, 1'b0);       // single piece
    run_req(64'h0000_0000_0000_FFF0, 27'h40, 1'b0, 1'b0);        // R4 boundary cut
    run_req(64'h0000_0000_0002_0000, 27'd0, 1'b1, 1'b0);        // R8 zero length
    run_req(64'h0000_0000_0003_0000, 27'd1024, 1'b0, 1'b0);     // R5 code 1
    run_req(64'h0000_0000_0004_0000, 27'd32767, 1'b1, 1'b0);    // R5 code 31
    run_req(64'h0000_0000_0005_0000, 27'd32768, 1'b0, 1'b0);    // R5 saturation
    bp_mode = 1'b1;
    run_req(64'h0001_2345_0000_8000, 27'd200000, 1'b1, 1'b0);   // R9 back-pressure
    run_req(64'h0000_0000_0000_FFFF, 27'd3, 1'b0, 1'b0);        // R6 two pieces
    bp_mode = 1'b0;
    run_req(64'h0000_0000_0100_0000, 27'h400_0001, 1'b1, 1'b1); // R10 over limit
    run_req(64'h0000_0000_0100_0000, 27'h400_0000, 1'b1, 1'b0); // R10 at limit

    chk(done_cnt == good_reqs, "R11 done count", 128'(done_cnt), 128'(good_reqs));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=hung expected=complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule